// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block sits between the external active-low reset pin and the system reset logic. It synchronises the raw pin into the bus clock domain and qualifies it before it may raise a reset request. Short glitches on the pin are rejected so that noise cannot reset the chip.

Two filter engines run side by side on the synchronised pin. The first counts bus-clock samples against a programmable width. The second counts samples taken only on a low-power oscillator tick, and needs a fixed number of them. A 2-bit run/wait mode code picks one engine, or no filtering at all.

In stop mode the bus-clock engine is never used. A separate stop enable chooses between the tick-based engine and the unfiltered pin. The output is an active-high reset request for the rest of the reset controller.

Top module: `rst_pin_filter`

## Requirements
- R1: After reset `req_o` is 0, and it stays 0 while the pin is held high.
- R2: The raw pin passes through two flops before any filter. With filtering off, `req_o` takes the inverted pin value two clock edges after the pin is sampled.
- R3: Run mode codes 0 (off) and 3 (reserved) both give an unfiltered request.
- R4: In run mode code 1 (bus-clock filter), `req_o` rises only after W+1 consecutive low synchronised samples, where W = `bus_width_i`. This is the (W+3)th edge after the pin falls. A low pulse of W or fewer clocks is ignored.
- R5: In run mode code 1, `req_o` falls after W+1 consecutive high synchronised samples. This is the (W+3)th edge after the pin rises.
- R6: In run mode code 2 (tick filter), `req_o` rises on the third consecutive low sample taken with `lpo_tick_i` high. Cycles without a tick take no sample. A high sample on a tick restarts the count.
- R7: In run mode code 2, `req_o` falls on the third consecutive high sample taken on a tick.
- R8: With `stop_i`=1 and `stop_filt_en_i`=0, the request is unfiltered whatever the run mode.
- R9: With `stop_i`=1 and `stop_filt_en_i`=1, the tick filter is used. The bus-clock filter and `bus_width_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_ni | input | 1 | Raw external reset pin, active low |
| lpo_tick_i | input | 1 | One-cycle enable marking a low-power clock sample |
| stop_i | input | 1 | Chip is in stop mode |
| stop_filt_en_i | input | 1 | Use the tick filter while in stop mode |
| run_mode_i | input | 2 | Run/wait filter select: 0 off, 1 bus clock, 2 tick, 3 off |
| bus_width_i | input | WIDTH_W | Bus-clock filter width W (W+1 samples) |
| req_o | output | 1 | Filtered reset request, active high |

## Verification
Several properties are checked on every cycle. The synchronised pin must equal the raw pin from two edges earlier. Each filter engine may only flip towards the level it last sampled, and the tick engine only after a tick. Every mode selection must route the proper source to `req_o`.

Only the bench scenarios show the exact latencies. These are the W+3 edge delay swept over a range of widths in both directions, glitch rejection just below the width, the three-tick count and its restart, and the fact that the width has no effect in stop mode.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_BUS  = 2'd1,
    MODE_LPO  = 2'd2,
    MODE_RSVD = 2'd3
  } run_mode_e;

  typedef enum logic [1:0] {
    SRC_PASS = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_LPO  = 2'd2
  } src_sel_e;

  function automatic src_sel_e pick_src(logic stop, logic stop_en, logic [1:0] mode);
    if (stop) return stop_en ? SRC_LPO : SRC_PASS;
    case (run_mode_e'(mode))
      MODE_BUS: return SRC_BUS;
      MODE_LPO: return SRC_LPO;
      default:  return SRC_PASS;
    endcase
  endfunction
endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_low_o
);
  logic [STAGES-1:0] sync_q;

  // resets to released pin level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], pin_ni};
  end

  assign pin_low_o = ~sync_q[STAGES-1];
endmodule

// File: rtl/rpf_run_filter.sv
module rpf_run_filter #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_en_i,
  input  logic          level_i,
  input  logic [CW-1:0] limit_i,
  output logic          state_o
);
  logic          state_q;
  logic [CW-1:0] cnt_q;

  // flips after limit+1 consecutive disagreeing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sample_en_i) begin
      if (level_i != state_q) begin
        if (cnt_q == limit_i) begin
          state_q <= level_i;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rst_pin_filter.sv
module rst_pin_filter
  import rpf_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int LPO_SAMPLES = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_ni,
  input  logic               lpo_tick_i,
  input  logic               stop_i,
  input  logic               stop_filt_en_i,
  input  logic [1:0]         run_mode_i,
  input  logic [WIDTH_W-1:0] bus_width_i,
  output logic               req_o
);
  localparam int LPO_CW = (LPO_SAMPLES > 2) ? $clog2(LPO_SAMPLES) : 1;
  localparam logic [LPO_CW-1:0] LPO_LIMIT = LPO_CW'(LPO_SAMPLES - 1);

  logic     sync_low;
  logic     bus_req;
  logic     lpo_req;
  src_sel_e sel;

  rpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_ni    (pin_ni),
    .pin_low_o (sync_low)
  );

  rpf_run_filter #(.CW(WIDTH_W)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_en_i (1'b1),
    .level_i     (sync_low),
    .limit_i     (bus_width_i),
    .state_o     (bus_req)
  );

  rpf_run_filter #(.CW(LPO_CW)) u_lpo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_en_i (lpo_tick_i),
    .level_i     (sync_low),
    .limit_i     (LPO_LIMIT),
    .state_o     (lpo_req)
  );

  assign sel = pick_src(stop_i, stop_filt_en_i, run_mode_i);

  always_comb begin
    case (sel)
      SRC_BUS: req_o = bus_req;
      SRC_LPO: req_o = lpo_req;
      default: req_o = sync_low;
    endcase
  end
endmodule

// File: rtl/rpf_chk.sv
module rpf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pin_ni,
  input logic       lpo_tick_i,
  input logic       stop_i,
  input logic       stop_filt_en_i,
  input logic [1:0] run_mode_i,
  input logic       req_o,
  input logic       sync_low,
  input logic       bus_req,
  input logic       lpo_req
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd0) |-> !req_o || sync_low);

  p_sync_two_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> sync_low == !$past(pin_ni, 2));

  p_off_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_i && (run_mode_i == 2'd0 || run_mode_i == 2'd3)) |-> req_o == sync_low);

  p_bus_agree_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bus_req) |-> bus_req == $past(sync_low));

  p_lpo_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lpo_req) |-> $past(lpo_tick_i));

  p_lpo_agree_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lpo_req) |-> lpo_req == $past(sync_low));

  p_stop_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !stop_filt_en_i) |-> req_o == sync_low);

  p_stop_lpo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && stop_filt_en_i) |-> req_o == lpo_req);
endmodule

bind rst_pin_filter rpf_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pin_ni         (pin_ni),
  .lpo_tick_i     (lpo_tick_i),
  .stop_i         (stop_i),
  .stop_filt_en_i (stop_filt_en_i),
  .run_mode_i     (run_mode_i),
  .req_o          (req_o),
  .sync_low       (sync_low),
  .bus_req        (bus_req),
  .lpo_req        (lpo_req)
);

// File: tb/sim_rst_pin_filter.sv
module sim_rst_pin_filter;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH_W    = 8;
  localparam int MAX_SWEEP  = 7;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               pin_ni = 1'b1;
  logic               lpo_tick_i = 1'b0;
  logic               stop_i = 1'b0;
  logic               stop_filt_en_i = 1'b0;
  logic [1:0]         run_mode_i = 2'd0;
  logic [WIDTH_W-1:0] bus_width_i = '0;
  logic               req_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rst_pin_filter #(.WIDTH_W(WIDTH_W)) u0 (
    .clk_i, .rst_ni, .pin_ni, .lpo_tick_i, .stop_i, .stop_filt_en_i,
    .run_mode_i, .bus_width_i, .req_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    pin_ni = 1'b1;
    lpo_tick_i = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic tick();
    lpo_tick_i = 1'b1;
    cyc(1);
    lpo_tick_i = 1'b0;
  endtask

  // edges from a pin change until req_o reaches want
  task automatic latency(logic want, output int k);
    k = 0;
    while (req_o !== want && k < 300) begin
      cyc(1);
      k++;
    end
  endtask

  initial begin
    int k;
    do_reset();
    check("R1 reset req", req_o, 0);
    cyc(20);
    check("R1 idle req", req_o, 0);

    // R2/R3: modes 0 and 3 unfiltered, 2-edge latency
    for (int m = 0; m < 4; m += 3) begin
      do_reset();
      run_mode_i = 2'(m);
      bus_width_i = 8'd5;
      pin_ni = 1'b0;
      cyc(1);
      check("R2 no change after one edge", req_o, 0);
      cyc(1);
      check("R3 unfiltered assert", req_o, 1);
      pin_ni = 1'b1;
      latency(1'b0, k);
      check("R2 unfiltered release latency", k, 2);
    end

    // R4/R5: bus filter sweep over widths
    for (int w = 0; w <= MAX_SWEEP; w++) begin
      do_reset();
      run_mode_i = 2'd1;
      bus_width_i = WIDTH_W'(w);
      pin_ni = 1'b0;
      latency(1'b1, k);
      check("R4 bus assert latency", k, w + 3);
      pin_ni = 1'b1;
      latency(1'b0, k);
      check("R5 bus release latency", k, w + 3);
      if (w > 0) begin
        pin_ni = 1'b0;
        cyc(w);
        pin_ni = 1'b1;
        cyc(w + 10);
        check("R4 short pulse ignored", req_o, 0);
        pin_ni = 1'b0;
        cyc(w + 1);
        pin_ni = 1'b1;
        cyc(2);
        check("R4 pulse of width+1 accepted", req_o, 1);
      end
    end

    // R6/R7: tick filter
    do_reset();
    run_mode_i = 2'd2;
    bus_width_i = '0;
    pin_ni = 1'b0;
    cyc(50);
    check("R6 no ticks no assert", req_o, 0);
    tick();
    check("R6 one tick", req_o, 0);
    tick();
    check("R6 two ticks", req_o, 0);
    tick();
    check("R6 three ticks assert", req_o, 1);
    pin_ni = 1'b1;
    cyc(3);
    check("R7 held before ticks", req_o, 1);
    tick();
    tick();
    check("R7 two high ticks", req_o, 1);
    tick();
    check("R7 three high ticks release", req_o, 0);

    do_reset();
    run_mode_i = 2'd2;
    pin_ni = 1'b0;
    cyc(3);
    tick();
    tick();
    pin_ni = 1'b1;
    cyc(3);
    tick();
    pin_ni = 1'b0;
    cyc(3);
    tick();
    tick();
    check("R6 high tick restarts count", req_o, 0);
    tick();
    check("R6 restarted count completes", req_o, 1);

    // R8: stop without enable is unfiltered
    do_reset();
    stop_i = 1'b1;
    stop_filt_en_i = 1'b0;
    run_mode_i = 2'd1;
    bus_width_i = 8'd6;
    pin_ni = 1'b0;
    latency(1'b1, k);
    check("R8 stop unfiltered assert", k, 2);
    pin_ni = 1'b1;
    latency(1'b0, k);
    check("R8 stop unfiltered release", k, 2);

    // R9: stop with enable uses tick filter, width ignored
    do_reset();
    stop_i = 1'b1;
    stop_filt_en_i = 1'b1;
    run_mode_i = 2'd1;
    bus_width_i = '0;
    pin_ni = 1'b0;
    cyc(20);
    check("R9 bus filter bypassed in stop", req_o, 0);
    tick();
    tick();
    tick();
    check("R9 tick filter in stop", req_o, 1);
    stop_i = 1'b0;
    stop_filt_en_i = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule